// File: doc/BRIEF.md
# Tone Cadence Timer Controller

This block paces the on/off rhythm of one telephony tone generator. Two down-counting phase timers take turns. The "on" timer sets how long the tone sounds and the "off" timer sets the silent gap. Both timers advance on a slow cadence strobe (nominally 8 kHz). Each timer reloads from its own programmed period when it runs out, and control then passes to the other phase. The block drives an enable to the oscillator. That enable is refreshed only on the oscillator's own update strobe (nominally 16 kHz), so it never changes between two oscillator updates.

The end of a tone burst can optionally be held back until the oscillator reports a zero crossing, so that a burst is not cut off in the middle of a cycle. Each timer expiry sets its own pending flag. A flag reaches the shared interrupt line only while its enable is set, and it stays set until the host pulses the matching write-one-to-clear input. A master run input starts the cadence in the tone phase with both counters freshly loaded. Dropping the run input stops everything on the next clock.

Top module: `tone_cadence_ctrl`

## Requirements
- R1: After reset, osc_en, sig_active, on_pend, off_pend and irq are all 0, and the block is idle.
- R2: While idle, a high run_en moves the block into the tone phase on the next clock, so sig_active reads 1 one cycle later. Both timers are loaded from their periods at that moment.
- R3: In the tone phase with on_tmr_en high, the phase ends at the clock edge that samples the on_period-th tick_8k pulse. With zc_hold_en low, sig_active is 0 from the next cycle.
- R4: In the silent phase with off_tmr_en high, the phase ends at the off_period-th tick_8k pulse. The tone phase then starts again with the on timer reloaded, and the cycle repeats for as long as run_en stays high.
- R5: A phase whose timer enable is low never ends on its own, however many tick_8k pulses arrive.
- R6: If zc_hold_en is high when the tone timer expires, sig_active stays 1 until a cycle with osc_zero_x high. The silent phase begins on the clock after that cycle.
- R7: Every timer expiry sets that timer's pending flag (on_pend or off_pend). The flag stays set until a cycle with the matching clear input high. If an expiry arrives in the same cycle as the clear, the flag stays set.
- R8: irq equals (on_pend AND on_irq_en) OR (off_pend AND off_irq_en).
- R9: While run_en is high, osc_en takes the value of sig_active only at a clock where tick_16k is high. At every other clock it keeps its value.
- R10: A clock that samples run_en low puts the block into idle. After that clock, sig_active and osc_en both read 0.
- R11: A programmed period of 0 behaves like a period of 1, so the phase lasts one tick_8k pulse. The largest period, 2^CNT_W-1, lasts exactly that many pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Master cadence enable |
| on_tmr_en | input | 1 | Lets the tone-phase timer count |
| off_tmr_en | input | 1 | Lets the silent-phase timer count |
| zc_hold_en | input | 1 | Holds the end of the tone phase until a zero crossing |
| on_period | input | CNT_W (16) | Tone phase length in cadence ticks |
| off_period | input | CNT_W (16) | Silent phase length in cadence ticks |
| on_irq_en | input | 1 | Routes on_pend to irq |
| off_irq_en | input | 1 | Routes off_pend to irq |
| on_pend_clr | input | 1 | Write-one pulse that clears on_pend |
| off_pend_clr | input | 1 | Write-one pulse that clears off_pend |
| tick_8k | input | 1 | One-cycle cadence strobe |
| tick_16k | input | 1 | One-cycle oscillator update strobe |
| osc_zero_x | input | 1 | Zero-crossing indication from the oscillator |
| osc_en | output | 1 | Oscillator enable, changes only on tick_16k |
| sig_active | output | 1 | High during the tone phase, including the zero-cross wait |
| on_pend | output | 1 | Tone-timer expiry pending flag |
| off_pend | output | 1 | Silent-timer expiry pending flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench keeps the default counter width of 16 bits. Most of the run uses periods from 0 to 4, so that hundreds of random segments go through many full on/off rounds. In those rounds the bench hits zero-cross waits, clears that meet a fresh expiry, and stops in every phase. A directed case programs a period of 0xFFFF and strobes tick_8k on every clock. This puts the full-scale wrap of the 16-bit counter within about 65 thousand cycles.

// File: rtl/tcad_pkg.sv
package tcad_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_ZWAIT = 2'd2,
    PH_OFF   = 2'd3
  } phase_t;

  // Tone is audible while timing the on phase or waiting for a crossing.
  function automatic logic tone_on(input phase_t ph);
    return (ph == PH_ON) || (ph == PH_ZWAIT);
  endfunction

endpackage

// File: rtl/tcad_timer.sv
module tcad_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             step_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  // A count of 1 or 0 means this tick is the last one of the phase,
  // so a zero period lasts a single tick.
  function automatic logic at_end(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  assign expire_o = step_i && at_end(cnt_q);
  assign count_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= period_i;
    end else if (step_i) begin
      if (at_end(cnt_q)) cnt_q <= period_i;
      else               cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/tcad_phase.sv
module tcad_phase
  import tcad_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  input  logic   tick_8k,
  input  logic   on_tmr_en,
  input  logic   off_tmr_en,
  input  logic   zc_hold_en,
  input  logic   osc_zero_x,
  input  logic   on_exp,
  input  logic   off_exp,
  output phase_t phase_o,
  output logic   on_step,
  output logic   off_step,
  output logic   on_load,
  output logic   off_load
);

  phase_t ph_q, ph_d;

  assign phase_o  = ph_q;
  assign on_step  = run_en && tick_8k && on_tmr_en  && (ph_q == PH_ON);
  assign off_step = run_en && tick_8k && off_tmr_en && (ph_q == PH_OFF);

  always_comb begin
    ph_d     = ph_q;
    on_load  = 1'b0;
    off_load = 1'b0;
    if (!run_en) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d     = PH_ON;
          on_load  = 1'b1;
          off_load = 1'b1;
        end
        PH_ON: begin
          if (on_exp) begin
            if (zc_hold_en) begin
              ph_d = PH_ZWAIT;
            end else begin
              ph_d     = PH_OFF;
              off_load = 1'b1;
            end
          end
        end
        PH_ZWAIT: begin
          if (osc_zero_x) begin
            ph_d     = PH_OFF;
            off_load = 1'b1;
          end
        end
        PH_OFF: begin
          if (off_exp) begin
            ph_d    = PH_ON;
            on_load = 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/tcad_irq.sv
module tcad_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);

  logic [NCH-1:0] pend_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // A fresh event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= set_i[g] | (pend_q[g] & ~clr_i[g]);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);

endmodule

// File: rtl/tone_cadence_ctrl.sv
module tone_cadence_ctrl
  import tcad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             on_tmr_en,
  input  logic             off_tmr_en,
  input  logic             zc_hold_en,
  input  logic [CNT_W-1:0] on_period,
  input  logic [CNT_W-1:0] off_period,
  input  logic             on_irq_en,
  input  logic             off_irq_en,
  input  logic             on_pend_clr,
  input  logic             off_pend_clr,
  input  logic             tick_8k,
  input  logic             tick_16k,
  input  logic             osc_zero_x,
  output logic             osc_en,
  output logic             sig_active,
  output logic             on_pend,
  output logic             off_pend,
  output logic             irq
);

  localparam int NCH = 2;

  // Named internal events, visible to the bound checker.
  phase_t           phase;
  logic             on_step, off_step, on_load, off_load;
  logic             on_exp, off_exp;
  logic [CNT_W-1:0] on_cnt, off_cnt;
  logic [NCH-1:0]   pend_vec;
  logic             osc_en_q;

  tcad_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tick_8k    (tick_8k),
    .on_tmr_en  (on_tmr_en),
    .off_tmr_en (off_tmr_en),
    .zc_hold_en (zc_hold_en),
    .osc_zero_x (osc_zero_x),
    .on_exp     (on_exp),
    .off_exp    (off_exp),
    .phase_o    (phase),
    .on_step    (on_step),
    .off_step   (off_step),
    .on_load    (on_load),
    .off_load   (off_load)
  );

  tcad_timer #(.CNT_W(CNT_W)) u_on_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (on_load),
    .period_i (on_period),
    .step_i   (on_step),
    .expire_o (on_exp),
    .count_o  (on_cnt)
  );

  tcad_timer #(.CNT_W(CNT_W)) u_off_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (off_load),
    .period_i (off_period),
    .step_i   (off_step),
    .expire_o (off_exp),
    .count_o  (off_cnt)
  );

  tcad_irq #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({off_exp, on_exp}),
    .clr_i  ({off_pend_clr, on_pend_clr}),
    .en_i   ({off_irq_en, on_irq_en}),
    .pend_o (pend_vec),
    .irq_o  (irq)
  );

  // Oscillator enable follows the phase only at oscillator update strobes.
  always_ff @(posedge clk) begin
    if (!rst_n)        osc_en_q <= 1'b0;
    else if (!run_en)  osc_en_q <= 1'b0;
    else if (tick_16k) osc_en_q <= tone_on(phase);
  end

  assign osc_en     = osc_en_q;
  assign sig_active = tone_on(phase);
  assign on_pend    = pend_vec[0];
  assign off_pend   = pend_vec[1];

endmodule

// File: rtl/tcad_chk.sv
module tcad_chk
  import tcad_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   run_en,
  input logic   tick_16k,
  input logic   on_tmr_en,
  input logic   off_tmr_en,
  input logic   osc_zero_x,
  input logic   on_pend_clr,
  input logic   off_pend_clr,
  input phase_t phase,
  input logic   on_exp,
  input logic   off_exp,
  input logic   osc_en,
  input logic   sig_active,
  input logic   on_pend,
  input logic   off_pend
);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase == PH_IDLE) |=> (phase == PH_ON));

  // R5
  on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase == PH_ON && !on_tmr_en) |=> (phase == PH_ON));

  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase == PH_OFF && !off_tmr_en) |=> (phase == PH_OFF));

  // R6
  zc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && phase == PH_ZWAIT && !osc_zero_x) |=> (phase == PH_ZWAIT));

  // R7
  on_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_exp |=> on_pend);

  // R7
  off_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_exp |=> off_pend);

  // R7
  on_pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_pend_clr && !on_exp) |=> !on_pend);

  // R7
  off_pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_pend_clr && !off_exp) |=> !off_pend);

  // R9
  osc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick_16k) |=> $stable(osc_en));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!osc_en && !sig_active));

endmodule

bind tone_cadence_ctrl tcad_chk u_tcad_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .tick_16k     (tick_16k),
  .on_tmr_en    (on_tmr_en),
  .off_tmr_en   (off_tmr_en),
  .osc_zero_x   (osc_zero_x),
  .on_pend_clr  (on_pend_clr),
  .off_pend_clr (off_pend_clr),
  .phase        (phase),
  .on_exp       (on_exp),
  .off_exp      (off_exp),
  .osc_en       (osc_en),
  .sig_active   (sig_active),
  .on_pend      (on_pend),
  .off_pend     (off_pend)
);

// File: tb/test_tone_cadence_ctrl.sv
`timescale 1ns/1ps
module test_tone_cadence_ctrl;

  localparam int CNT_W = 16;
  localparam time TCLK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, on_tmr_en = 0, off_tmr_en = 0, zc_hold_en = 0;
  logic [CNT_W-1:0] on_period = '0, off_period = '0;
  logic on_irq_en = 0, off_irq_en = 0, on_pend_clr = 0, off_pend_clr = 0;
  logic tick_8k = 0, tick_16k = 0, osc_zero_x = 0;
  logic osc_en, sig_active, on_pend, off_pend, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_on = 1'b0;

  always #(TCLK/2) clk = ~clk;

  tone_cadence_ctrl #(.CNT_W(CNT_W)) i_tone_cadence_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .on_tmr_en(on_tmr_en),
    .off_tmr_en(off_tmr_en), .zc_hold_en(zc_hold_en), .on_period(on_period),
    .off_period(off_period), .on_irq_en(on_irq_en), .off_irq_en(off_irq_en),
    .on_pend_clr(on_pend_clr), .off_pend_clr(off_pend_clr), .tick_8k(tick_8k),
    .tick_16k(tick_16k), .osc_zero_x(osc_zero_x), .osc_en(osc_en),
    .sig_active(sig_active), .on_pend(on_pend), .off_pend(off_pend), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Phase length in ticks: zero counts as one (R11).
  function automatic int ticks_of(input logic [CNT_W-1:0] p);
    return (p == 0) ? 1 : int'(p);
  endfunction

  // ---- reference model: remaining-tick bookkeeping per phase ----
  int m_ph = 0;        // 0 idle, 1 tone, 2 waiting for crossing, 3 silent
  int m_left_on = 0, m_left_off = 0;
  bit m_pon = 0, m_poff = 0, m_osc = 0;

  always @(posedge clk) begin
    bit ev_on, ev_off;
    ev_on = 0; ev_off = 0;
    if (!rst_n) begin
      m_ph <= 0; m_pon <= 0; m_poff <= 0; m_osc <= 0;
    end else begin
      if (!run_en) begin
        m_ph <= 0;
      end else begin
        case (m_ph)
          0: begin m_ph <= 1; m_left_on <= ticks_of(on_period); end
          1: if (tick_8k && on_tmr_en) begin
               if (m_left_on == 1) begin
                 ev_on = 1;
                 if (zc_hold_en) m_ph <= 2;
                 else begin m_ph <= 3; m_left_off <= ticks_of(off_period); end
               end else m_left_on <= m_left_on - 1;
             end
          2: if (osc_zero_x) begin m_ph <= 3; m_left_off <= ticks_of(off_period); end
          default: if (tick_8k && off_tmr_en) begin
               if (m_left_off == 1) begin
                 ev_off = 1; m_ph <= 1; m_left_on <= ticks_of(on_period);
               end else m_left_off <= m_left_off - 1;
             end
        endcase
      end
      m_pon  <= ev_on  | (m_pon  & ~on_pend_clr);
      m_poff <= ev_off | (m_poff & ~off_pend_clr);
      if (!run_en)       m_osc <= 0;
      else if (tick_16k) m_osc <= (m_ph == 1 || m_ph == 2);
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R3 sig_active", sig_active, (m_ph == 1 || m_ph == 2));
      chk("R9 osc_en", osc_en, m_osc);
      chk("R7 on_pend", on_pend, m_pon);
      chk("R7 off_pend", off_pend, m_poff);
      chk("R8 irq", irq, (m_pon & on_irq_en) | (m_poff & off_irq_en));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse8();
    tick_8k = 1; @(negedge clk); tick_8k = 0; @(negedge clk);
  endtask

  task automatic restart();
    run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
  endtask

  // Count tick_8k pulses until sig_active falls.
  task automatic count_on_ticks(output int n);
    n = 0;
    while (sig_active && n < 100) begin pulse8(); n++; end
  endtask

  initial begin : watchdog
    #(TCLK * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1c3a5e77));
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 osc_en", osc_en, 0);
    chk("R1 sig_active", sig_active, 0);
    chk("R1 pend", {on_pend, off_pend}, 0);
    chk("R1 irq", irq, 0);
    model_on = 1;

    // R2 start, R3 tone length, R4 silent length
    on_period = 3; off_period = 2; on_tmr_en = 1; off_tmr_en = 1;
    run_en = 1; @(negedge clk);
    chk("R2 start", sig_active, 1);
    count_on_ticks(n);
    chk("R3 tone ticks", n, 3);
    pulse8();
    chk("R4 silent mid", sig_active, 0);
    pulse8();
    chk("R4 back to tone", sig_active, 1);
    chk("R7 both pending", {on_pend, off_pend}, 2'b11);
    on_irq_en = 1; @(negedge clk);
    chk("R8 irq on", irq, 1);
    on_pend_clr = 1; off_pend_clr = 1; @(negedge clk);
    on_pend_clr = 0; off_pend_clr = 0;
    chk("R7 cleared", {on_pend, off_pend}, 2'b00);
    chk("R8 irq off", irq, 0);

    // R11 zero period
    on_period = 0; restart();
    count_on_ticks(n);
    chk("R11 zero period", n, 1);

    // R5 disabled tone timer never ends
    on_period = 2; on_tmr_en = 0; restart();
    repeat (10) pulse8();
    chk("R5 disabled timer", sig_active, 1);
    on_tmr_en = 1;

    // R6 zero-cross hold
    on_period = 1; zc_hold_en = 1; restart();
    pulse8(); cyc(5);
    chk("R6 held", sig_active, 1);
    osc_zero_x = 1; @(negedge clk); osc_zero_x = 0;
    chk("R6 released", sig_active, 0);
    zc_hold_en = 0;

    // R7 clear meets new expiry
    on_period = 0; off_period = 0; restart();
    pulse8(); pulse8();
    on_pend_clr = 1; tick_8k = 1; @(negedge clk);
    on_pend_clr = 0; tick_8k = 0;
    chk("R7 set wins", on_pend, 1);

    // R9 osc_en only moves on tick_16k
    on_period = 4; restart(); cyc(4);
    chk("R9 held low", osc_en, 0);
    tick_16k = 1; @(negedge clk); tick_16k = 0;
    chk("R9 follows", osc_en, 1);

    // R10 stop
    run_en = 0; @(negedge clk);
    chk("R10 stop active", sig_active, 0);
    chk("R10 stop osc", osc_en, 0);

    // R11 full-scale period
    on_period = '1; run_en = 1; @(negedge clk);
    tick_8k = 1; n = 0;
    do begin @(negedge clk); n++; end while (sig_active && n < 70000);
    tick_8k = 0;
    chk("R11 max period", n, 65535);

    // Random segments
    for (int seg = 0; seg < 200; seg++) begin
      on_period  = CNT_W'($urandom % 5);
      off_period = CNT_W'($urandom % 5);
      on_tmr_en  = ($urandom % 10) != 0;
      off_tmr_en = ($urandom % 10) != 0;
      zc_hold_en = $urandom % 2;
      on_irq_en  = $urandom % 2;
      off_irq_en = $urandom % 2;
      for (int c = 0; c < 100; c++) begin
        tick_8k      = ($urandom % 3) == 0;
        tick_16k     = $urandom % 2;
        osc_zero_x   = ($urandom % 6) == 0;
        on_pend_clr  = ($urandom % 8) == 0;
        off_pend_clr = ($urandom % 8) == 0;
        run_en       = ($urandom % 64) != 0;
        @(negedge clk);
      end
    end
    tick_8k = 0; tick_16k = 0; osc_zero_x = 0; on_pend_clr = 0; off_pend_clr = 0;
    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule